// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block stores the gamma correction tables of several display channels and applies them to a pixel stream. A host loads the tables through a two-register port. One register holds an entry address and an auto-increment flag. The other register is a data window onto the table entry at that address. Each channel owns one region of 768 eight-bit entries: the red curve, then the green curve, then the blue curve. The regions of the channels follow one another in channel order.

On the pixel side, each valid RGB pixel is tagged with a channel number. If that channel's gamma enable is set and the table storage is powered, each colour component is replaced by its table entry. Otherwise the pixel passes through unchanged. Both paths take exactly one clock, so the output is in step whichever path is used.

The storage is powered only while at least one channel enable is set. A small power state machine has three states:
- `PWR_SCRUB`: the storage is being cleared. The block enters it at reset, and from `PWR_ON` when every enable drops. It clears one location of every colour bank per cycle. On the last location it moves to `PWR_ON` if any enable is set, or to `PWR_OFF` if none is.
- `PWR_OFF`: the storage is powered down. The block moves to `PWR_ON` as soon as any enable is set.
- `PWR_ON`: lookups and host data accesses are served. The block returns to `PWR_SCRUB` when all enables clear.

Clearing models the loss of contents, so software must reload the tables after every power-down.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset the block clears the storage, which takes 768 cycles. Before the first pixel, `out_vld` is 0 and `host_rdata` is 0. Once clearing is done, every table entry reads back as 0.
- R2: The entry for channel c, colour k (0 = red, 1 = green, 2 = blue) and input value i is at address c*768 + k*256 + i.
- R3: A write with `host_sel`=1 while `PWR_ON` is the active state stores `host_wdata[7:0]` at the current address. If the auto-increment flag is set, the address then advances by one.
- R4: When the auto-increment flag is clear, data writes and data reads leave the address unchanged. A second write to the same address overwrites the first.
- R5: A read with `host_sel`=1 while `PWR_ON` is the active state returns the entry at the current address in `host_rdata[7:0]`, with the upper bits 0, in the cycle after the strobe. If the auto-increment flag is set, the address then advances by one.
- R6: A write with `host_sel`=0 loads the address from `host_wdata[11:0]` and the auto-increment flag from `host_wdata[15]`. A read with `host_sel`=0 returns the flag in bit 15, the address in bits 11:0 and 0 in all other bits, in the cycle after the strobe.
- R7: An advance from the last address, 2303, wraps to 0. An address written above 2303 is stored as 0.
- R8: `out_vld` follows `pix_vld` one cycle later. If the channel's enable is set while `PWR_ON` is active, each output component is that channel's table entry for the input component.
- R9: A pixel whose channel enable is clear comes out unchanged, with the same one-cycle latency.
- R10: When all enables clear, every stored entry is lost and later reads back as 0. While the state is `PWR_SCRUB` or `PWR_OFF`, data writes are ignored, data reads return 0, and the address does not advance.
- R11: While the state is `PWR_SCRUB`, pixels bypass the tables even if their channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gamma_en | input | 3 | Gamma enable, one bit per channel |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Register select: 0 = address register, 1 = data register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid the cycle after a read strobe |
| pix_vld | input | 1 | Input pixel valid |
| pix_ch | input | 2 | Channel of the input pixel |
| pix_r | input | 8 | Red component in |
| pix_g | input | 8 | Green component in |
| pix_b | input | 8 | Blue component in |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 8 | Red component out |
| out_g | output | 8 | Green component out |
| out_b | output | 8 | Blue component out |

## Verification
The hardest situation to reach from the ports is the loss of contents. The tables must be loaded and proven live through lookups. Every enable must then drop, and an enable must come back while the clearing is still under way. The stimulus does exactly this. It disables all channels and, during the clear, probes the data register and sends a pixel on a re-enabled channel. Both must show that nothing is served. After the clear, the earlier table values must read back as zero through both the host port and the pixel path. The wrap at address 2303 is reached by loading the address register directly. Its effect is observed through the blue entry of the last channel.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    typedef enum logic [1:0] {
        PWR_SCRUB = 2'd0,
        PWR_OFF   = 2'd1,
        PWR_ON    = 2'd2
    } pwr_state_t;

    typedef enum logic [1:0] {
        RSP_ZERO = 2'd0,
        RSP_ADDR = 2'd1,
        RSP_DATA = 2'd2
    } rsp_kind_t;

    localparam int COLOURS = 3;

endpackage

// File: rtl/gamma_power_fsm.sv
module gamma_power_fsm
    import gamma_lut_pkg::*;
#(
    parameter int BANK_N  = 768,
    parameter int BANK_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_en,
    output pwr_state_t         state,
    output logic               scrub_we,
    output logic [BANK_AW-1:0] scrub_addr,
    output logic               lut_on
);

    localparam logic [BANK_AW-1:0] SCRUB_LAST = BANK_AW'(BANK_N - 1);

    pwr_state_t         nxt;
    logic [BANK_AW-1:0] cnt;

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            PWR_SCRUB: if (cnt == SCRUB_LAST) nxt = any_en ? PWR_ON : PWR_OFF;
            PWR_OFF:   if (any_en)            nxt = PWR_ON;
            PWR_ON:    if (!any_en)           nxt = PWR_SCRUB;
            default:                          nxt = PWR_SCRUB;
        endcase
    end

    // State register and clear counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PWR_SCRUB;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == PWR_SCRUB && nxt == PWR_SCRUB) ? cnt + 1'b1 : '0;
        end
    end

    // Outputs
    always_comb begin
        scrub_we   = 1'b0;
        lut_on     = 1'b0;
        scrub_addr = cnt;
        unique case (state)
            PWR_SCRUB: scrub_we = 1'b1;
            PWR_ON:    lut_on   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/gamma_host_port.sv
module gamma_host_port
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int ENT_W       = 8,
    parameter int HOST_W      = 16,
    parameter int AUTOINC_BIT = 15,
    parameter int CH_W        = 2,
    parameter int ADDR_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lut_on,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic                    host_sel,
    input  logic [HOST_W-1:0]       host_wdata,
    output logic [ADDR_W-1:0]       cur_addr,
    output logic                    autoinc,
    output logic                    data_we,
    output logic [1:0]              acc_col,
    output logic [CH_W+ENT_W-1:0]   acc_bank_addr,
    output rsp_kind_t               rsp_kind,
    output logic [1:0]              rsp_col,
    output logic [HOST_W-1:0]       addr_snap
);

    localparam int IDX_N   = 1 << ENT_W;
    localparam int TABLE_N = COLOURS * IDX_N;
    localparam int TOTAL   = NUM_CH * TABLE_N;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

    logic              data_rd;
    logic              step;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [CH_W-1:0]   ch_sel;
    logic [ADDR_W-1:0] rem;

    assign data_we  = host_wr & host_sel & lut_on;
    assign data_rd  = host_rd & host_sel & lut_on & ~host_wr;
    assign step     = (data_we | data_rd) & autoinc;
    assign nxt_addr = (cur_addr == LAST) ? '0 : cur_addr + 1'b1;
    assign wr_addr  = (host_wdata[ADDR_W-1:0] > LAST) ? '0 : host_wdata[ADDR_W-1:0];

    // Split the linear address into channel, colour and index
    always_comb begin
        ch_sel = '0;
        for (int c = 1; c < NUM_CH; c++) begin
            if (cur_addr >= ADDR_W'(c * TABLE_N)) ch_sel = CH_W'(c);
        end
        rem = cur_addr - ADDR_W'(int'(ch_sel) * TABLE_N);
    end

    assign acc_col       = rem[ENT_W+1:ENT_W];
    assign acc_bank_addr = {ch_sel, rem[ENT_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            autoinc  <= 1'b0;
        end else if (host_wr && !host_sel) begin
            cur_addr <= wr_addr;
            autoinc  <= host_wdata[AUTOINC_BIT];
        end else if (step) begin
            cur_addr <= nxt_addr;
        end
    end

    // Read response bookkeeping for the data path mux in the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_kind  <= RSP_ZERO;
            rsp_col   <= '0;
            addr_snap <= '0;
        end else if (host_rd && !host_wr) begin
            rsp_col <= acc_col;
            if (!host_sel) begin
                rsp_kind                  <= RSP_ADDR;
                addr_snap                 <= '0;
                addr_snap[ADDR_W-1:0]     <= cur_addr;
                addr_snap[AUTOINC_BIT]    <= autoinc;
            end else begin
                rsp_kind <= lut_on ? RSP_DATA : RSP_ZERO;
            end
        end
    end

endmodule

// File: rtl/gamma_bank.sv
module gamma_bank #(
    parameter int DEPTH = 768,
    parameter int AW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] pix_addr,
    output logic [DW-1:0] pix_q,
    input  logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_q
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        pix_q  <= mem[pix_addr];
        host_q <= mem[host_addr];
    end

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int ENT_W       = 8,
    parameter int HOST_W      = 16,
    parameter int AUTOINC_BIT = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             gamma_en,
    input  logic                          host_wr,
    input  logic                          host_rd,
    input  logic                          host_sel,
    input  logic [HOST_W-1:0]             host_wdata,
    output logic [HOST_W-1:0]             host_rdata,
    input  logic                          pix_vld,
    input  logic [$clog2(NUM_CH)-1:0]     pix_ch,
    input  logic [ENT_W-1:0]              pix_r,
    input  logic [ENT_W-1:0]              pix_g,
    input  logic [ENT_W-1:0]              pix_b,
    output logic                          out_vld,
    output logic [ENT_W-1:0]              out_r,
    output logic [ENT_W-1:0]              out_g,
    output logic [ENT_W-1:0]              out_b
);

    localparam int CH_W    = $clog2(NUM_CH);
    localparam int IDX_N   = 1 << ENT_W;
    localparam int TOTAL   = NUM_CH * COLOURS * IDX_N;
    localparam int ADDR_W  = $clog2(TOTAL);
    localparam int BANK_N  = NUM_CH * IDX_N;
    localparam int BANK_AW = CH_W + ENT_W;

    pwr_state_t          pwr_state;
    logic                scrub_we;
    logic [BANK_AW-1:0]  scrub_addr;
    logic                lut_on;
    logic                any_en;

    logic [ADDR_W-1:0]   cur_addr;
    logic                autoinc;
    logic                data_we;
    logic [1:0]          acc_col;
    logic [BANK_AW-1:0]  acc_bank_addr;
    rsp_kind_t           rsp_kind;
    logic [1:0]          rsp_col;
    logic [HOST_W-1:0]   addr_snap;

    logic [ENT_W-1:0]    pix_in   [COLOURS];
    logic [ENT_W-1:0]    pix_hold [COLOURS];
    logic [ENT_W-1:0]    lut_q    [COLOURS];
    logic [ENT_W-1:0]    host_q   [COLOURS];
    logic [COLOURS-1:0]  bank_we;
    logic                use_lut;
    logic                use_q;
    logic                vld_q;

    assign any_en = |gamma_en;

    gamma_power_fsm #(.BANK_N(BANK_N), .BANK_AW(BANK_AW)) u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_en     (any_en),
        .state      (pwr_state),
        .scrub_we   (scrub_we),
        .scrub_addr (scrub_addr),
        .lut_on     (lut_on)
    );

    gamma_host_port #(
        .NUM_CH(NUM_CH), .ENT_W(ENT_W), .HOST_W(HOST_W),
        .AUTOINC_BIT(AUTOINC_BIT), .CH_W(CH_W), .ADDR_W(ADDR_W)
    ) u_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .lut_on        (lut_on),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_sel      (host_sel),
        .host_wdata    (host_wdata),
        .cur_addr      (cur_addr),
        .autoinc       (autoinc),
        .data_we       (data_we),
        .acc_col       (acc_col),
        .acc_bank_addr (acc_bank_addr),
        .rsp_kind      (rsp_kind),
        .rsp_col       (rsp_col),
        .addr_snap     (addr_snap)
    );

    assign pix_in[0] = pix_r;
    assign pix_in[1] = pix_g;
    assign pix_in[2] = pix_b;

    generate
        for (genvar k = 0; k < COLOURS; k++) begin : g_bank
            assign bank_we[k] = scrub_we | (data_we & (acc_col == 2'(k)));

            gamma_bank #(.DEPTH(BANK_N), .AW(BANK_AW), .DW(ENT_W)) u_bank (
                .clk       (clk),
                .we        (bank_we[k]),
                .waddr     (scrub_we ? scrub_addr : acc_bank_addr),
                .wdata     (scrub_we ? '0 : host_wdata[ENT_W-1:0]),
                .pix_addr  ({pix_ch, pix_in[k]}),
                .pix_q     (lut_q[k]),
                .host_addr (acc_bank_addr),
                .host_q    (host_q[k])
            );

            always_ff @(posedge clk) begin
                pix_hold[k] <= pix_in[k];
            end
        end
    endgenerate

    always_comb begin
        use_lut = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (pix_ch == CH_W'(c) && gamma_en[c]) use_lut = lut_on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            use_q <= 1'b0;
        end else begin
            vld_q <= pix_vld;
            use_q <= use_lut;
        end
    end

    assign out_vld = vld_q;
    assign out_r   = use_q ? lut_q[0] : pix_hold[0];
    assign out_g   = use_q ? lut_q[1] : pix_hold[1];
    assign out_b   = use_q ? lut_q[2] : pix_hold[2];

    always_comb begin
        host_rdata = '0;
        unique case (rsp_kind)
            RSP_ADDR: host_rdata = addr_snap;
            RSP_DATA: begin
                unique case (rsp_col)
                    2'd0:    host_rdata[ENT_W-1:0] = host_q[0];
                    2'd1:    host_rdata[ENT_W-1:0] = host_q[1];
                    default: host_rdata[ENT_W-1:0] = host_q[2];
                endcase
            end
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ENT_W  = 8,
    parameter int HOST_W = 16,
    parameter int ADDR_W = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      host_wr,
    input logic                      host_sel,
    input logic [NUM_CH-1:0]         gamma_en,
    input logic                      pix_vld,
    input logic [$clog2(NUM_CH)-1:0] pix_ch,
    input logic [ENT_W-1:0]          pix_r,
    input logic                      out_vld,
    input logic [ENT_W-1:0]          out_r,
    input logic [1:0]                pwr_state,
    input logic [ADDR_W-1:0]         cur_addr,
    input logic                      autoinc,
    input logic [2:0]                bank_we
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_CH * COLOURS * (1 << ENT_W) - 1);

    logic past_ok;
    logic ch_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        ch_en = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (pix_ch == $clog2(NUM_CH)'(c)) ch_en = gamma_en[c];
        end
    end

    assert_vld_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_vld == $past(pix_vld)));

    assert_bypass_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pix_vld && !ch_en)) |-> (out_r == $past(pix_r)));

    assert_autoinc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(host_wr && host_sel && autoinc && pwr_state == PWR_ON))
        |-> (cur_addr == (($past(cur_addr) == LAST) ? '0 : $past(cur_addr) + 1'b1)));

    assert_addr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_addr <= LAST);

    assert_off_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_OFF) |-> (bank_we == 3'b000));

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pwr_state != PWR_ON && !(host_wr && !host_sel))) |-> $stable(cur_addr));

endmodule

bind gamma_lut_top gamma_lut_chk #(
    .NUM_CH(NUM_CH), .ENT_W(ENT_W), .HOST_W(HOST_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_sel  (host_sel),
    .gamma_en  (gamma_en),
    .pix_vld   (pix_vld),
    .pix_ch    (pix_ch),
    .pix_r     (pix_r),
    .out_vld   (out_vld),
    .out_r     (out_r),
    .pwr_state (pwr_state),
    .cur_addr  (cur_addr),
    .autoinc   (autoinc),
    .bank_we   (bank_we)
);

// File: tb/gamma_lut_top_tb_top.sv
module gamma_lut_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  gamma_en = 3'b000;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        pix_vld = 1'b0;
    logic [1:0]  pix_ch = '0;
    logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_vld;
    logic [7:0]  out_r, out_g, out_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gamma_lut_top dut_i (
        .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_vld(pix_vld), .pix_ch(pix_ch),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic logic [7:0] expv(int c, int k, int i);
        return 8'((i * (c + 3)) + k * 37 + c * 11 + 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(logic sel, logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(logic sel, output logic [15:0] v);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic pixel(int ch, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                         output logic [23:0] o, output logic v);
        @(negedge clk);
        pix_vld = 1'b1; pix_ch = 2'(ch); pix_r = r; pix_g = g; pix_b = b;
        @(negedge clk);
        pix_vld = 1'b0;
        o = {out_r, out_g, out_b};
        v = out_vld;
    endtask

    task automatic load_channel(int c);
        host_write(1'b0, 16'h8000 | 16'(c * 768));
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < 256; i++)
                host_write(1'b1, {8'h00, expv(c, k, i)});
    endtask

    task automatic t_reset;
        logic [23:0] o; logic v;
        check("R1 out_vld at reset", 32'(out_vld), 0);
        check("R1 host_rdata at reset", 32'(host_rdata), 0);
        repeat (800) @(negedge clk);
        gamma_en = 3'b001;
        pixel(0, 8'd5, 8'd200, 8'd77, o, v);
        check("R1 cleared table lookup", 32'(o), 0);
        check("R8 out_vld follows pix_vld", 32'(v), 1);
        @(negedge clk);
        check("R8 out_vld drops", 32'(out_vld), 0);
    endtask

    task automatic t_lookup;
        logic [23:0] o; logic v;
        load_channel(0);
        load_channel(1);
        gamma_en = 3'b011;
        pixel(0, 8'd0, 8'd1, 8'd255, o, v);
        check("R2 R8 ch0 lookup", 32'(o), 32'({expv(0,0,0), expv(0,1,1), expv(0,2,255)}));
        pixel(1, 8'd17, 8'd128, 8'd3, o, v);
        check("R2 R8 ch1 lookup", 32'(o), 32'({expv(1,0,17), expv(1,1,128), expv(1,2,3)}));
        pixel(1, 8'd255, 8'd0, 8'd90, o, v);
        check("R2 R8 ch1 lookup edges", 32'(o), 32'({expv(1,0,255), expv(1,1,0), expv(1,2,90)}));
    endtask

    task automatic t_bypass;
        logic [23:0] o; logic v;
        gamma_en = 3'b001;
        pixel(1, 8'd17, 8'd128, 8'd3, o, v);
        check("R9 disabled ch1 passes", 32'(o), 32'({8'd17, 8'd128, 8'd3}));
        check("R9 latency valid", 32'(v), 1);
        pixel(2, 8'hA5, 8'h5A, 8'h0F, o, v);
        check("R9 disabled ch2 passes", 32'(o), 32'h00A55A0F);
        pixel(0, 8'd9, 8'd9, 8'd9, o, v);
        check("R8 ch0 still mapped", 32'(o), 32'({expv(0,0,9), expv(0,1,9), expv(0,2,9)}));
    endtask

    task automatic t_noinc;
        logic [15:0] v;
        host_write(1'b0, 16'(2 * 768 + 5));
        host_write(1'b1, 16'h0011);
        host_write(1'b1, 16'h0022);
        host_read(1'b0, v);
        check("R4 R6 address held, flag clear", 32'(v), 32'(2 * 768 + 5));
        host_read(1'b1, v);
        check("R4 second write overwrote", 32'(v), 32'h22);
        host_read(1'b0, v);
        check("R4 read leaves address", 32'(v), 32'(2 * 768 + 5));
    endtask

    task automatic t_read_inc;
        logic [15:0] v;
        host_write(1'b0, 16'h8000 | 16'(768 + 256 + 3));
        for (int i = 3; i < 6; i++) begin
            host_read(1'b1, v);
            check("R5 data read", 32'(v), 32'(expv(1, 1, i)));
        end
        host_read(1'b0, v);
        check("R5 R6 address advanced by reads", 32'(v), 32'(16'h8000 | 16'(768 + 256 + 6)));
    endtask

    task automatic t_wrap;
        logic [15:0] v; logic [23:0] o; logic vv;
        host_write(1'b0, 16'h8000 | 16'd2303);
        host_write(1'b1, 16'h0077);
        host_read(1'b0, v);
        check("R7 wrap to zero", 32'(v), 32'h8000);
        gamma_en = 3'b101;
        pixel(2, 8'd0, 8'd0, 8'd255, o, vv);
        check("R2 last entry is ch2 blue 255", 32'(o[7:0]), 32'h77);
        host_write(1'b0, 16'd3000);
        host_read(1'b0, v);
        check("R7 out-of-range address stored as 0", 32'(v), 0);
    endtask

    task automatic t_power;
        logic [15:0] v; logic [23:0] o; logic vv;
        host_write(1'b0, 16'h8000 | 16'd7);
        gamma_en = 3'b000;
        @(negedge clk);
        host_write(1'b1, 16'h00EE);
        host_read(1'b0, v);
        check("R10 ignored write keeps address", 32'(v), 32'h8007);
        host_read(1'b1, v);
        check("R10 data read while powered down", 32'(v), 0);
        host_read(1'b0, v);
        check("R10 ignored read keeps address", 32'(v), 32'h8007);
        gamma_en = 3'b001;
        pixel(0, 8'd7, 8'd8, 8'd9, o, vv);
        check("R11 bypass while clearing", 32'(o), 32'h00070809);
        repeat (800) @(negedge clk);
        pixel(0, 8'd7, 8'd8, 8'd9, o, vv);
        check("R10 table lost after power down", 32'(o), 0);
        host_read(1'b1, v);
        check("R10 entry reads zero", 32'(v), 0);
        host_write(1'b0, 16'd2303);
        host_read(1'b1, v);
        check("R10 last entry reads zero", 32'(v), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lookup();
        t_bypass();
        t_noinc();
        t_read_inc();
        t_wrap();
        t_power();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule